// File: doc/BRIEF.md
# Three-Wire Serial Control Receiver

This block receives control frames over a three-line serial interface (an enable line, a serial clock and a data line) and updates three holding registers: a 4-bit band selection, a 15-bit divider ratio and a 7-bit test word. All three bus lines are oversampled by a fast system clock through two-flop synchronizers. Rising and falling edges are detected on the synchronized copies. A frame starts on a rising edge of enable. Each rising edge of the serial clock that follows samples one data bit. Each register group is transferred at a fixed pulse position or, for the short divider format, on the enable edge that ends the frame.

Three frame lengths are understood: 18 bits (band plus 14 divider bits, divider MSB cleared), 19 bits (band plus a full 15-bit divider) and 34 bits (band, divider, then 7 test bits on pulses 20 to 26 followed by padding). Frames of any other length are not rejected. Every group whose transfer point was reached keeps its new value, and every other group keeps its previous value. The serial clock is slow (100 kHz or less), so each bus level lasts many system clocks. The receiver assumes that each level is held for at least 4 system clock cycles.

Top module: `tw_ctrl_rx`

## Requirements
- R1: While reset is asserted and after it is released, before any frame arrives, the band output is 0, the divider output is the parameter DIV_RST (default 256, that is 15'h0100) and the test output is 0.
- R2: Serial clock pulses that occur while enable is low, or before a rising edge of enable, change no output.
- R3: The data bits on pulses 1 to 4 form the band value, first bit in bit 3. The band output takes this value on the falling edge of pulse 4, while enable is still high.
- R4: The data bits on pulses 5 to 19 form the divider value, first bit in bit 14. The divider output takes this value on the falling edge of pulse 19 and does not change before that edge.
- R5: When enable falls after exactly 18 pulses, the divider output becomes the 14 bits from pulses 5 to 18 in bits 13..0, and bit 14 is 0.
- R6: The data bits on pulses 20 to 26 form the test value, first bit in bit 6. The test output takes this value on the falling edge of pulse 34.
- R7: A frame that ends before a group's transfer point leaves that group unchanged. A group whose transfer point was reached keeps its new value.
- R8: Pulses after the 34th pulse of a frame change no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Frame enable line; a rising edge starts a frame |
| bus_clk | input | 1 | Serial bit clock; data is sampled on its rising edge |
| bus_data | input | 1 | Serial data line |
| band_o | output | 4 | Band selection register |
| div_o | output | 15 | Divider ratio register |
| test_o | output | 7 | Test word register |

## Verification
The bench first sweeps all 16 band codes in 19-bit frames, each paired with a distinct divider word. This separates the band field from the divider field and tests the bit order within each. It then alternates 19-bit frames that set the divider MSB with 18-bit frames. The result shows whether the short format clears bit 14 rather than keeping a stale bit. A sweep of the frame length from 0 to 40 pulses, with a new pattern for each length, shows which groups each length must update and which it must leave alone. This covers truncated frames, the 34-pulse test transfer and the pulses beyond it that must be ignored. Probes taken in the middle of a frame confirm that the band loads on pulse 4 and that the divider holds its old value up to pulse 19. Pulses sent while enable is low confirm that nothing shifts outside a frame.

// File: rtl/tw_pkg.sv
package tw_pkg;

  // One flag per holding-register transfer event, valid for one system clock.
  typedef struct packed {
    logic band;        // band group transfer
    logic div_full;    // divider transfer, all bits
    logic div_short;   // divider transfer, MSB cleared
    logic test;        // test group transfer
  } tw_load_t;

endpackage

// File: rtl/tw_sync.sv
// Two-flop synchronizer bank for asynchronous bus lines.
module tw_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  for (genvar i = 0; i < W; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= 1'b0;
        sync_q[i] <= 1'b0;
      end else begin
        meta_q[i] <= din[i];
        sync_q[i] <= meta_q[i];
      end
    end
  end

  assign lvl = sync_q;

endmodule

// File: rtl/tw_shreg.sv
// Field shift register: MSB-first serial load under a shift enable.
module tw_shreg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q
);

  logic [W-1:0] sr_q;
  logic [W-1:0] sr_d;

  always_comb begin
    sr_d = sr_q;
    if (shift_en) begin
      if (W > 1) sr_d = {sr_q[W-2:0], din};
      else       sr_d = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign q = sr_q;

endmodule

// File: rtl/tw_frame_ctrl.sv
// Frame sequencer: edge detection, pulse counting, field steering, transfer events.
module tw_frame_ctrl
  import tw_pkg::*;
#(
  parameter int BAND_W    = 4,
  parameter int DIV_W     = 15,
  parameter int TEST_W    = 7,
  parameter int FRAME_MAX = 34,
  parameter int CNT_W     = $clog2(FRAME_MAX + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_lvl,
  input  logic             sck_lvl,
  output logic             sh_band,
  output logic             sh_div,
  output logic             sh_test,
  output tw_load_t         load,
  output logic [CNT_W-1:0] cnt_o
);

  localparam int DIV_HI  = BAND_W + DIV_W;
  localparam int TST_HI  = DIV_HI + TEST_W;
  localparam int CNT_SAT = FRAME_MAX + 1;

  localparam logic [CNT_W-1:0] C_BAND_END = CNT_W'(BAND_W);
  localparam logic [CNT_W-1:0] C_DIV_END  = CNT_W'(DIV_HI);
  localparam logic [CNT_W-1:0] C_DIV_SHRT = CNT_W'(DIV_HI - 1);
  localparam logic [CNT_W-1:0] C_TST_END  = CNT_W'(TST_HI);
  localparam logic [CNT_W-1:0] C_FRM_END  = CNT_W'(FRAME_MAX);
  localparam logic [CNT_W-1:0] C_SAT      = CNT_W'(CNT_SAT);

  logic             en_prev_q, sck_prev_q;
  logic             active_q, active_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en_rise, en_fall, sck_rise, sck_fall;
  logic             take;
  logic [CNT_W-1:0] pulse_num;

  assign en_rise  =  en_lvl  & ~en_prev_q;
  assign en_fall  = ~en_lvl  &  en_prev_q;
  assign sck_rise =  sck_lvl & ~sck_prev_q;
  assign sck_fall = ~sck_lvl &  sck_prev_q;

  // A bit is taken on a rising serial clock inside an open frame, up to the limit.
  assign take      = active_q & sck_rise & (cnt_q != C_SAT);
  assign pulse_num = cnt_q + 1'b1;

  always_comb begin
    active_d = active_q;
    if (en_rise)      active_d = 1'b1;
    else if (en_fall) active_d = 1'b0;

    cnt_d = cnt_q;
    if (en_rise)   cnt_d = '0;
    else if (take) cnt_d = pulse_num;
  end

  always_comb begin
    sh_band = take & (pulse_num <= C_BAND_END);
    sh_div  = take & (pulse_num >  C_BAND_END) & (pulse_num <= C_DIV_END);
    sh_test = take & (pulse_num >  C_DIV_END)  & (pulse_num <= C_TST_END);

    load.band      = active_q & sck_fall & (cnt_q == C_BAND_END);
    load.div_full  = active_q & sck_fall & (cnt_q == C_DIV_END);
    load.div_short = active_q & en_fall  & (cnt_q == C_DIV_SHRT);
    load.test      = active_q & sck_fall & (cnt_q == C_FRM_END);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_prev_q  <= 1'b0;
      sck_prev_q <= 1'b0;
      active_q   <= 1'b0;
      cnt_q      <= '0;
    end else begin
      en_prev_q  <= en_lvl;
      sck_prev_q <= sck_lvl;
      active_q   <= active_d;
      cnt_q      <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= C_SAT); // R8

  AST_NO_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> !(sh_band | sh_div | sh_test)); // R2

endmodule

// File: rtl/tw_ctrl_rx.sv
// Three-wire serial control receiver: top level with holding registers.
module tw_ctrl_rx
  import tw_pkg::*;
#(
  parameter int BAND_W    = 4,
  parameter int DIV_W     = 15,
  parameter int TEST_W    = 7,
  parameter int FRAME_MAX = 34,
  parameter int DIV_RST   = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_clk,
  input  logic              bus_data,
  output logic [BAND_W-1:0] band_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [TEST_W-1:0] test_o
);

  localparam int CNT_W = $clog2(FRAME_MAX + 2);
  localparam logic [CNT_W-1:0] C_BAND_END = CNT_W'(BAND_W);
  localparam logic [CNT_W-1:0] C_DIV_END  = CNT_W'(BAND_W + DIV_W);
  localparam logic [CNT_W-1:0] C_DIV_SHRT = CNT_W'(BAND_W + DIV_W - 1);
  localparam logic [CNT_W-1:0] C_FRM_END  = CNT_W'(FRAME_MAX);

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [2:0] line_lvl;
  tw_sync #(.W(3)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .din   ({bus_en, bus_clk, bus_data}),
    .lvl   (line_lvl)
  );

  logic             sh_band, sh_div, sh_test;
  tw_load_t         load;
  logic [CNT_W-1:0] cnt;

  tw_frame_ctrl #(
    .BAND_W    (BAND_W),
    .DIV_W     (DIV_W),
    .TEST_W    (TEST_W),
    .FRAME_MAX (FRAME_MAX),
    .CNT_W     (CNT_W)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .en_lvl  (line_lvl[2]),
    .sck_lvl (line_lvl[1]),
    .sh_band (sh_band),
    .sh_div  (sh_div),
    .sh_test (sh_test),
    .load    (load),
    .cnt_o   (cnt)
  );

  logic [BAND_W-1:0] band_sr;
  logic [DIV_W-1:0]  div_sr;
  logic [TEST_W-1:0] test_sr;

  tw_shreg #(.W(BAND_W)) u_band_sr (
    .clk(clk), .rst_n(rst_sync_q), .shift_en(sh_band), .din(line_lvl[0]), .q(band_sr));
  tw_shreg #(.W(DIV_W)) u_div_sr (
    .clk(clk), .rst_n(rst_sync_q), .shift_en(sh_div), .din(line_lvl[0]), .q(div_sr));
  tw_shreg #(.W(TEST_W)) u_test_sr (
    .clk(clk), .rst_n(rst_sync_q), .shift_en(sh_test), .din(line_lvl[0]), .q(test_sr));

  // Holding registers: each group updates only on its own transfer event.
  logic [BAND_W-1:0] band_q, band_d;
  logic [DIV_W-1:0]  div_q,  div_d;
  logic [TEST_W-1:0] test_q, test_d;

  always_comb begin
    band_d = band_q;
    if (load.band) band_d = band_sr;

    div_d = div_q;
    if (load.div_full)       div_d = div_sr;
    else if (load.div_short) div_d = {1'b0, div_sr[DIV_W-2:0]};

    test_d = test_q;
    if (load.test) test_d = test_sr;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      band_q <= '0;
      div_q  <= DIV_W'(DIV_RST);
      test_q <= '0;
    end else begin
      band_q <= band_d;
      div_q  <= div_d;
      test_q <= test_d;
    end
  end

  assign band_o = band_q;
  assign div_o  = div_q;
  assign test_o = test_q;

  AST_BAND_AT_P4: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (band_q != $past(band_q)) |-> ($past(cnt) == C_BAND_END)); // R3

  AST_DIV_AT_END: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (div_q != $past(div_q)) |-> ($past(cnt) == C_DIV_END || $past(cnt) == C_DIV_SHRT)); // R4

  AST_SHORT_MSB_CLR: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (div_q != $past(div_q) && $past(cnt) == C_DIV_SHRT) |-> !div_q[DIV_W-1]); // R5

  AST_TEST_AT_END: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (test_q != $past(test_q)) |-> ($past(cnt) == C_FRM_END)); // R6

endmodule

// File: tb/tw_ctrl_rx_tb_top.sv
module tw_ctrl_rx_tb_top;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, bus_en, bus_clk, bus_data;
  logic [3:0]  band_o;
  logic [14:0] div_o;
  logic [6:0]  test_o;

  tw_ctrl_rx dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_clk(bus_clk), .bus_data(bus_data),
    .band_o(band_o), .div_o(div_o), .test_o(test_o)
  );

  localparam int HALF = 6;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [3:0]  e_band;
  logic [14:0] e_div;
  logic [6:0]  e_test;

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tb, string td, string tt);
    chk(tb, 32'(band_o), 32'(e_band));
    chk(td, 32'(div_o),  32'(e_div));
    chk(tt, 32'(test_o), 32'(e_test));
  endtask

  // Expected register update for a frame of len pulses carrying pat (bit k on pulse k+1).
  task automatic model(logic [63:0] pat, int len);
    if (len >= 4) begin
      e_band = '0;
      for (int i = 0; i < 4; i++) e_band = {e_band[2:0], pat[i]};
    end
    if (len >= 19) begin
      for (int i = 4; i < 19; i++) e_div = {e_div[13:0], pat[i]};
    end else if (len == 18) begin
      for (int i = 4; i < 18; i++) e_div = {e_div[13:0], pat[i]};
      e_div[14] = 1'b0;
    end
    if (len >= 34) begin
      for (int i = 19; i < 26; i++) e_test = {e_test[5:0], pat[i]};
    end
  endtask

  task automatic send(logic [63:0] pat, int len, bit probe);
    logic [3:0] pb;
    bus_en = 1'b1;
    wait_cyc(HALF);
    for (int k = 0; k < len; k++) begin
      bus_data = pat[k];
      wait_cyc(HALF);
      bus_clk = 1'b1;
      wait_cyc(HALF);
      bus_clk = 1'b0;
      wait_cyc(HALF);
      if (probe && k == 3) begin
        pb = {pat[0], pat[1], pat[2], pat[3]};
        chk("R3 band loaded at pulse 4 fall", 32'(band_o), 32'(pb));
      end
      if (probe && k == 17)
        chk("R4 divider held before pulse 19", 32'(div_o), 32'(e_div));
    end
    bus_data = 1'b0;
    bus_en   = 1'b0;
    wait_cyc(2 * HALF);
    model(pat, len);
  endtask

  function automatic logic [63:0] frame19(logic [3:0] b, logic [14:0] d);
    logic [63:0] p = '0;
    for (int i = 0; i < 4; i++)  p[i]     = b[3-i];
    for (int j = 0; j < 15; j++) p[4+j]   = d[14-j];
    return p;
  endfunction

  function automatic logic [63:0] frame18(logic [3:0] b, logic [13:0] d);
    logic [63:0] p = '0;
    for (int i = 0; i < 4; i++)  p[i]   = b[3-i];
    for (int j = 0; j < 14; j++) p[4+j] = d[13-j];
    return p;
  endfunction

  initial begin
    rst_n = 1'b0; bus_en = 1'b0; bus_clk = 1'b0; bus_data = 1'b0;
    e_band = 4'h0; e_div = 15'h0100; e_test = 7'h0;
    wait_cyc(5);
    chk_all("R1 band reset", "R1 divider reset", "R1 test reset");
    rst_n = 1'b1;
    wait_cyc(4);
    chk_all("R1 band after release", "R1 divider after release", "R1 test after release");

    // R2: pulses with enable low
    bus_data = 1'b1;
    for (int k = 0; k < 36; k++) begin
      bus_clk = 1'b1; wait_cyc(HALF);
      bus_clk = 1'b0; wait_cyc(HALF);
    end
    bus_data = 1'b0;
    chk_all("R2 band idle pulses", "R2 divider idle pulses", "R2 test idle pulses");

    // R3/R4: all band codes with distinct divider words
    for (int v = 0; v < 16; v++) begin
      logic [14:0] d;
      d = 15'((v * 1237) ^ 15'h4A5B);
      send(frame19(4'(v), d), 19, 1'b0);
      chk("R3 band sweep", 32'(band_o), 32'(v));
      chk("R4 divider 19-bit", 32'(div_o), 32'(d));
      chk("R6 test untouched by 19-bit", 32'(test_o), 32'(e_test));
    end

    // R5: 18-bit frames following frames that set the MSB
    for (int v = 0; v < 8; v++) begin
      logic [13:0] d;
      d = 14'((v * 2909) ^ 14'h2D3C);
      send(frame19(4'(15 - v), 15'h7000 | 15'(v)), 19, 1'b0);
      chk("R4 divider MSB set", 32'(div_o[14]), 32'd1);
      send(frame18(4'(v), d), 18, 1'b0);
      chk("R5 divider 18-bit", 32'(div_o), 32'({1'b0, d}));
      chk("R5 band in 18-bit", 32'(band_o), 32'(v));
    end

    // R6/R7/R8: frame length sweep
    for (int len = 0; len <= 40; len++) begin
      logic [63:0] pat;
      pat = 64'h9E3779B97F4A7C15 * 64'(len + 3);
      send(pat, len, 1'b0);
      if (len > 34)
        chk_all("R8 band long frame", "R8 divider long frame", "R8 test long frame");
      else if (len == 34)
        chk_all("R6 band 34-bit", "R6 divider 34-bit", "R6 test 34-bit");
      else
        chk_all("R7 band short frame", "R7 divider short frame", "R7 test short frame");
    end

    // Mid-frame probes
    send(frame19(4'hA, 15'h1234), 19, 1'b1);
    chk_all("R3 band probe frame", "R4 divider probe frame", "R7 test probe frame");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1..all actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule